// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block is the per-cache coherence engine of a small shared-bus multiprocessor. It keeps a direct-mapped array of line tags, each tagged with a coherence state held as three bits (valid, dirty, shared). It turns processor loads and stores into bus transactions. The transactions are plain read, read-for-ownership, invalidate and writeback. It answers the transactions of other caches that it observes on the bus. The data array, the memory behind the bus and arbitration between several caches belong to the surrounding system. The block sees only a single-master request/acknowledge handshake.

A processor request is held on the `cpu_*` pins until `cpu_done` pulses. Hits that need no bus traffic finish one cycle after acceptance. Misses and upgrades drive `bus_req` with a command and address until `bus_ack`. In the acknowledged cycle the block samples `bus_shared_in`, which the system builds from the other caches' shared responses. When another cache owns the bus, the system presents that transaction on the `snp_*` inputs. The block then answers in the same cycle with `snp_shared`, `snp_supply` and `snp_wb`, and its line state changes at the next edge.

A dirty line can be passed to a reader without a memory update. The line stays in the Owned state and this cache keeps answering reads for it. A read-only lookup port (`probe_addr` → `probe_state`) reports the state of any address.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid. `probe_state` gives {valid,dirty,shared}: Modified=3'b110, Owned=3'b111, Exclusive=3'b100, Shared=3'b101, and 3'b000 for an absent or Invalid line.
- R2: A read miss issues bus command 1 (read). At acknowledge the line fills Exclusive when `bus_shared_in` is low and Shared when it is high. A read hit causes no bus transaction and no state change.
- R3: A store that hits a line in Exclusive or Modified leaves it Modified. No bus transaction is issued, and `cpu_done` pulses in the cycle after acceptance.
- R4: A store that hits a line in Shared or Owned issues command 3 (invalidate) and becomes Modified at acknowledge. If a snooped invalidation removes the line while the request waits, the request turns into a read-for-ownership.
- R5: A store miss issues command 2 (read-for-ownership) and fills the line as Modified.
- R6: When a snooped read (command 1) hits a valid line, `snp_shared` is asserted. Modified moves to Owned and Owned stays Owned, both supplying data without writeback. Exclusive supplies data and moves to Shared. Shared stays Shared and does not supply.
- R7: When a snooped read-for-ownership or invalidate hits a valid line, the line becomes Invalid. A dirty line hit by a snooped read-for-ownership asserts `snp_wb`.
- R8: A miss whose victim is Modified or Owned first issues command 4 (writeback) for the victim address and then the fill. A clean victim is replaced silently.
- R9: `bus_req`, `bus_cmd` and `bus_addr` stay unchanged until `bus_ack`, unless a snoop intervenes. `cpu_done` is a single-cycle pulse.
- R10: With two caches on one bus, a line is never Modified or Exclusive in one cache while it is valid in the other.
- R11: A snoop whose tag does not match the stored line, or whose command is writeback, leaves the line unchanged and asserts none of the snoop responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 writeback |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_shared_in | input | 1 | Another cache keeps a copy (valid with `bus_ack`) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Command of the observed transaction |
| snp_addr | input | ADDR_W | Address of the observed transaction |
| snp_shared | output | 1 | This cache keeps a copy after the observed read |
| snp_supply | output | 1 | This cache provides the data |
| snp_wb | output | 1 | This cache writes its dirty copy back |
| probe_addr | input | ADDR_W | Lookup address |
| probe_state | output | 3 | {valid,dirty,shared} of `probe_addr` |

## Verification
The embedded properties check, every cycle, the transitions that a single controller decides. These are the silent Exclusive-to-Modified store, the upgrade ending in Modified, the Exclusive fill on an unshared read, Modified turning Owned on a snooped read without writeback, invalidation on ownership snoops, writebacks only of dirty victims, and the bus handshake. The two-cache bench scenarios are the only place where the single-writer rule of R10 shows. The same holds for the order of writeback before refill, the handover of an Owned line, and the race in which two caches upgrade the same Shared line at once.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPG  = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;

  typedef struct packed {
    logic v;
    logic d;
    logic s;
  } line_st_t;

  typedef enum logic [1:0] {
    F_IDLE,
    F_EVICT,
    F_FETCH,
    F_UPGR
  } fsm_e;

  localparam line_st_t ST_I = 3'b000;
  localparam line_st_t ST_M = 3'b110;
  localparam line_st_t ST_O = 3'b111;
  localparam line_st_t ST_E = 3'b100;
  localparam line_st_t ST_S = 3'b101;

  // valid and dirty: Modified or Owned
  function automatic logic is_dirty(line_st_t st);
    return st.v & st.d;
  endfunction

  // sole copy: Modified or Exclusive
  function automatic logic can_write(line_st_t st);
    return st.v & ~st.s;
  endfunction

  function automatic line_st_t fill_state(logic we, logic shared_in);
    if (we) return ST_M;
    return shared_in ? ST_S : ST_E;
  endfunction

  // observed read keeps dirtiness and marks shared; ownership takes it away
  function automatic line_st_t snoop_next(line_st_t st, bus_cmd_e cmd);
    line_st_t nxt;
    nxt = st;
    case (cmd)
      CMD_RD:           nxt = st.v ? line_st_t'({1'b1, st.d, 1'b1}) : ST_I;
      CMD_RDX, CMD_UPG: nxt = ST_I;
      default:          nxt = st;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/moesi_line.sv
module moesi_line
  import moesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_t         wr_st,
  output logic [TAG_W-1:0] tag_q,
  output line_st_t         st_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      st_q  <= ST_I;
    end else if (wr_en) begin
      tag_q <= wr_tag;
      st_q  <= wr_st;
    end
  end

endmodule

// File: rtl/moesi_snoop.sv
module moesi_snoop
  import moesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             snp_valid,
  input  bus_cmd_e         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_t         line_st,
  output logic             hit,
  output logic             upd,
  output logic             kill,
  output logic             shared,
  output logic             supply,
  output logic             wb,
  output line_st_t         next_st
);

  always_comb begin
    hit     = snp_valid && line_st.v && (line_tag == snp_tag);
    kill    = hit && (snp_cmd == CMD_RDX || snp_cmd == CMD_UPG);
    upd     = hit && (snp_cmd == CMD_RD || kill);
    shared  = hit && (snp_cmd == CMD_RD);
    supply  = shared && (line_st.d || !line_st.s);
    wb      = hit && (snp_cmd == CMD_RDX) && line_st.d;
    next_st = snoop_next(line_st, snp_cmd);
  end

endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic              snp_wb,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [2:0]        probe_state
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_t         st_q  [LINES];

  fsm_e              fsm_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              done_q;

  // ---------------- processor-side lookup ----------------
  logic [ADDR_W-1:0] c_addr;
  logic [IDX_W-1:0]  c_idx;
  logic [TAG_W-1:0]  c_tag;
  line_st_t          c_st;
  logic              c_hit;

  assign c_addr = (fsm_q == F_IDLE) ? cpu_addr : req_addr_q;
  assign c_idx  = c_addr[IDX_W-1:0];
  assign c_tag  = c_addr[ADDR_W-1:IDX_W];
  assign c_st   = st_q[c_idx];
  assign c_hit  = c_st.v && (tag_q[c_idx] == c_tag);

  // named events
  logic ev_accept, ev_rd_hit, ev_wr_silent, ev_wr_upg, ev_miss, ev_evict_dirty;
  logic ev_ack_wb, ev_ack_fetch, ev_ack_upg, ev_kill_pending;

  assign ev_accept      = (fsm_q == F_IDLE) && cpu_req && !done_q && !snp_valid;
  assign ev_rd_hit      = ev_accept && !cpu_we && c_hit;
  assign ev_wr_silent   = ev_accept && cpu_we && c_hit && can_write(c_st);
  assign ev_wr_upg      = ev_accept && cpu_we && c_hit && !can_write(c_st);
  assign ev_miss        = ev_accept && !c_hit;
  assign ev_evict_dirty = ev_miss && is_dirty(c_st);
  assign ev_ack_wb      = (fsm_q == F_EVICT) && bus_ack;
  assign ev_ack_fetch   = (fsm_q == F_FETCH) && bus_ack;
  assign ev_ack_upg     = (fsm_q == F_UPGR) && bus_ack;

  // ---------------- snoop-side lookup ----------------
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  line_st_t         s_st;
  logic             s_hit, s_upd, s_kill;
  line_st_t         s_next;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign s_st  = st_q[s_idx];

  moesi_snoop #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bus_cmd_e'(snp_cmd)),
    .snp_tag   (s_tag),
    .line_tag  (tag_q[s_idx]),
    .line_st   (s_st),
    .hit       (s_hit),
    .upd       (s_upd),
    .kill      (s_kill),
    .shared    (snp_shared),
    .supply    (snp_supply),
    .wb        (snp_wb),
    .next_st   (s_next)
  );

  // a pending upgrade or victim writeback loses its line to an observed invalidation
  assign ev_kill_pending = s_kill && (s_idx == c_idx) &&
                           (fsm_q == F_UPGR || fsm_q == F_EVICT);

  // ---------------- controller state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q      <= F_IDLE;
      req_we_q   <= 1'b0;
      req_addr_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= ev_rd_hit | ev_wr_silent | ev_ack_fetch | ev_ack_upg;
      case (fsm_q)
        F_IDLE: if (ev_accept) begin
          req_we_q   <= cpu_we;
          req_addr_q <= cpu_addr;
          if (ev_wr_upg)           fsm_q <= F_UPGR;
          else if (ev_evict_dirty) fsm_q <= F_EVICT;
          else if (ev_miss)        fsm_q <= F_FETCH;
        end
        F_EVICT: if (ev_kill_pending || bus_ack) fsm_q <= F_FETCH;
        F_FETCH: if (bus_ack) fsm_q <= F_IDLE;
        F_UPGR: begin
          if (ev_kill_pending) fsm_q <= F_FETCH;
          else if (bus_ack)    fsm_q <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  // ---------------- single line-write port (snoop first) ----------------
  logic             w_en;
  logic [IDX_W-1:0] w_idx;
  logic [TAG_W-1:0] w_tag;
  line_st_t         w_st;

  always_comb begin
    w_en  = 1'b1;
    w_idx = c_idx;
    w_tag = c_tag;
    w_st  = ST_M;
    if (s_upd) begin
      w_idx = s_idx;
      w_tag = tag_q[s_idx];
      w_st  = s_next;
    end else if (ev_ack_wb) begin
      w_tag = tag_q[c_idx];
      w_st  = ST_I;
    end else if (ev_ack_fetch) begin
      w_st  = fill_state(req_we_q, bus_shared_in);
    end else if (!(ev_wr_silent || ev_ack_upg)) begin
      w_en  = 1'b0;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    moesi_line #(.TAG_W(TAG_W)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (w_en && (w_idx == IDX_W'(i))),
      .wr_tag (w_tag),
      .wr_st  (w_st),
      .tag_q  (tag_q[i]),
      .st_q   (st_q[i])
    );
  end

  // ---------------- outputs ----------------
  bus_cmd_e cmd_e;
  always_comb begin
    case (fsm_q)
      F_EVICT: cmd_e = CMD_WB;
      F_FETCH: cmd_e = req_we_q ? CMD_RDX : CMD_RD;
      F_UPGR:  cmd_e = CMD_UPG;
      default: cmd_e = CMD_NONE;
    endcase
  end

  assign bus_req  = (fsm_q != F_IDLE);
  assign bus_cmd  = cmd_e;
  assign bus_addr = (fsm_q == F_EVICT) ? {tag_q[c_idx], c_idx} : req_addr_q;
  assign cpu_done = done_q;

  logic [IDX_W-1:0] p_idx;
  assign p_idx = probe_addr[IDX_W-1:0];
  assign probe_state = (st_q[p_idx].v && tag_q[p_idx] == probe_addr[ADDR_W-1:IDX_W])
                       ? st_q[p_idx] : ST_I;

  // ---------------- assertions ----------------
  a_r3_silent_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_silent |=> !bus_req && cpu_done && st_q[$past(c_idx)] == ST_M);

  a_r4_upgrade_to_m: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_upg |=> st_q[$past(c_idx)] == ST_M);

  a_r2_unshared_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack_fetch && !req_we_q && !bus_shared_in) |=> st_q[$past(c_idx)] == ST_E);

  a_r6_m_to_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && snp_cmd == CMD_RD && s_st == ST_M) |=> st_q[$past(s_idx)] == ST_O);

  a_r6_no_wb_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == CMD_RD) |-> !snp_wb);

  a_r7_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && (snp_cmd == CMD_RDX || snp_cmd == CMD_UPG)) |=> !st_q[$past(s_idx)].v);

  a_r8_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == CMD_WB) |-> is_dirty(c_st));

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !snp_valid) |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

endmodule

// File: tb/moesi_ctrl_tb.sv
module moesi_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // cache A (dut_i) and cache B (peer_i)
  logic          req_a = 0, we_a = 0, req_b = 0, we_b = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic          done_a, done_b;
  logic          breq_a, breq_b;
  logic [2:0]    bcmd_a, bcmd_b;
  logic [AW-1:0] baddr_a, baddr_b;
  logic          ack_a = 0, ack_b = 0;
  logic          sa_v = 0, sb_v = 0;
  logic [2:0]    sa_cmd = '0, sb_cmd = '0;
  logic [AW-1:0] sa_addr = '0, sb_addr = '0;
  logic          sa_sh, sa_sup, sa_wb, sb_sh, sb_sup, sb_wb;
  logic [AW-1:0] pa = '0, pb = '0;
  logic [2:0]    st_a, st_b;

  moesi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(req_a), .cpu_we(we_a), .cpu_addr(addr_a), .cpu_done(done_a),
    .bus_req(breq_a), .bus_cmd(bcmd_a), .bus_addr(baddr_a),
    .bus_ack(ack_a), .bus_shared_in(sb_sh),
    .snp_valid(sa_v), .snp_cmd(sa_cmd), .snp_addr(sa_addr),
    .snp_shared(sa_sh), .snp_supply(sa_sup), .snp_wb(sa_wb),
    .probe_addr(pa), .probe_state(st_a)
  );

  moesi_ctrl peer_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(req_b), .cpu_we(we_b), .cpu_addr(addr_b), .cpu_done(done_b),
    .bus_req(breq_b), .bus_cmd(bcmd_b), .bus_addr(baddr_b),
    .bus_ack(ack_b), .bus_shared_in(sa_sh),
    .snp_valid(sb_v), .snp_cmd(sb_cmd), .snp_addr(sb_addr),
    .snp_shared(sb_sh), .snp_supply(sb_sup), .snp_wb(sb_wb),
    .probe_addr(pb), .probe_state(st_b)
  );

  int total = 0, fails = 0;
  logic manual = 1'b0;
  int ntx_a = 0, ntx_b = 0, nwb = 0, nsup = 0;
  logic [2:0] fcmd = '0;
  logic finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus model: fixed priority to A, grant for one cycle, snoop shown to the other cache
  initial begin
    forever begin
      @(negedge clk);
      if (!manual) begin
        ack_a = 0; ack_b = 0; sa_v = 0; sb_v = 0;
        if (rst_n && breq_a) begin
          ack_a = 1; sb_v = 1; sb_cmd = bcmd_a; sb_addr = baddr_a;
          #1;
          if (ntx_a == 0 && ntx_b == 0) fcmd = bcmd_a;
          ntx_a++;
          if (sb_wb) nwb++;
          if (sb_sup) nsup++;
        end else if (rst_n && breq_b) begin
          ack_b = 1; sa_v = 1; sa_cmd = bcmd_b; sa_addr = baddr_b;
          #1;
          if (ntx_a == 0 && ntx_b == 0) fcmd = bcmd_b;
          ntx_b++;
          if (sa_wb) nwb++;
          if (sa_sup) nsup++;
        end
      end
    end
  end

  task automatic cpu_op(input int who, input logic we, input logic [AW-1:0] a);
    int n;
    @(negedge clk);
    if (who == 0) begin req_a = 1; we_a = we; addr_a = a; end
    else          begin req_b = 1; we_b = we; addr_b = a; end
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!((who == 0) ? done_a : done_b) && n < 200);
    if (n >= 200) chk("R9 request never completed", 0, 1);
    if (who == 0) req_a = 0; else req_b = 0;
  endtask

  task automatic probe(input logic [AW-1:0] a);
    @(negedge clk);
    pa = a; pb = a;
    #1;
  endtask

  // R10: no sole-copy state in one cache while the other holds the line
  task automatic single_writer(input logic [AW-1:0] a);
    probe(a);
    chk("R10 A sole copy while B valid", int'(st_a[2] && !st_a[0] && st_b[2]), 0);
    chk("R10 B sole copy while A valid", int'(st_b[2] && !st_b[0] && st_a[2]), 0);
  endtask

  typedef struct packed {
    logic          who;
    logic          we;
    logic [AW-1:0] addr;
    logic [2:0]    ea;
    logic [2:0]    eb;
    logic [1:0]    ntx;
    logic          wb;
    logic          sup;
    logic [2:0]    fcmd;
  } vec_t;

  // states: M=6 O=7 E=4 S=5 I=0; commands: RD=1 RDX=2 UPG=3 WB=4
  localparam vec_t VEC [13] = '{
    '{1'b0, 1'b0, 8'h10, 3'd4, 3'd0, 2'd1, 1'b0, 1'b0, 3'd1},  // R2 lone read -> E
    '{1'b1, 1'b0, 8'h10, 3'd5, 3'd5, 2'd1, 1'b0, 1'b1, 3'd1},  // R6 E supplies, both S
    '{1'b0, 1'b1, 8'h10, 3'd6, 3'd0, 2'd1, 1'b0, 1'b0, 3'd3},  // R4 S upgrade
    '{1'b1, 1'b0, 8'h10, 3'd7, 3'd5, 2'd1, 1'b0, 1'b1, 3'd1},  // R6 M -> O
    '{1'b0, 1'b0, 8'h10, 3'd7, 3'd5, 2'd0, 1'b0, 1'b0, 3'd0},  // R2 read hit on O
    '{1'b1, 1'b1, 8'h10, 3'd0, 3'd6, 2'd1, 1'b0, 1'b0, 3'd3},  // R7 upgrade kills O
    '{1'b0, 1'b1, 8'h10, 3'd6, 3'd0, 2'd1, 1'b1, 1'b0, 3'd2},  // R5 R7 miss vs M
    '{1'b1, 1'b1, 8'h20, 3'd0, 3'd6, 2'd1, 1'b0, 1'b0, 3'd2},  // R5 R11 other tag
    '{1'b0, 1'b0, 8'h20, 3'd5, 3'd7, 2'd2, 1'b0, 1'b1, 3'd4},  // R8 dirty victim
    '{1'b0, 1'b1, 8'h14, 3'd6, 3'd0, 2'd1, 1'b0, 1'b0, 3'd2},  // R8 clean victim
    '{1'b1, 1'b0, 8'h15, 3'd0, 3'd4, 2'd1, 1'b0, 1'b0, 3'd1},  // R2 E fill
    '{1'b1, 1'b1, 8'h15, 3'd0, 3'd6, 2'd0, 1'b0, 1'b0, 3'd0},  // R3 silent E->M
    '{1'b0, 1'b0, 8'h15, 3'd5, 3'd7, 2'd1, 1'b0, 1'b1, 3'd1}   // R6 M supplies
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      probe(AW'(i));
      chk("R1 reset A", int'(st_a), 0);
      chk("R1 reset B", int'(st_b), 0);
    end
    chk("R1 no request after reset", int'(breq_a | breq_b | done_a | done_b), 0);

    // table walk
    for (int k = 0; k < 13; k++) begin
      ntx_a = 0; ntx_b = 0; nwb = 0; nsup = 0; fcmd = '0;
      cpu_op(int'(VEC[k].who), VEC[k].we, VEC[k].addr);
      probe(VEC[k].addr);
      chk($sformatf("vec%0d state A R2 R3 R4 R5 R6 R7", k), int'(st_a), int'(VEC[k].ea));
      chk($sformatf("vec%0d state B R2 R3 R4 R5 R6 R7", k), int'(st_b), int'(VEC[k].eb));
      chk($sformatf("vec%0d bus txns R3 R8", k), ntx_a + ntx_b, int'(VEC[k].ntx));
      chk($sformatf("vec%0d first cmd R2 R4 R5 R8", k), int'(fcmd), int'(VEC[k].fcmd));
      chk($sformatf("vec%0d writeback R7", k), nwb, int'(VEC[k].wb));
      chk($sformatf("vec%0d supply R6", k), nsup, int'(VEC[k].sup));
      single_writer(VEC[k].addr);
    end

    // R11: mismatching tag and writeback snoops are ignored (A holds 0x15 in S)
    @(negedge clk);
    manual = 1'b1;
    sa_v = 1; sa_cmd = 3'd1; sa_addr = 8'h19;
    #1;
    chk("R11 tag mismatch responses", int'({sa_sh, sa_sup, sa_wb}), 0);
    @(negedge clk);
    sa_cmd = 3'd4; sa_addr = 8'h15;
    #1;
    chk("R11 writeback snoop responses", int'({sa_sh, sa_sup, sa_wb}), 0);
    @(negedge clk);
    sa_v = 0;
    manual = 1'b0;
    probe(8'h15);
    chk("R11 line unchanged", int'(st_a), 5);

    // R4 race: A (S) and B (O) upgrade the same line together; A wins the bus
    ntx_a = 0; ntx_b = 0; nwb = 0; nsup = 0;
    fork
      cpu_op(0, 1'b1, 8'h15);
      cpu_op(1, 1'b1, 8'h15);
    join
    probe(8'h15);
    chk("R4 race loser state A", int'(st_a), 0);
    chk("R4 race winner-after state B", int'(st_b), 6);
    chk("R4 A transactions", ntx_a, 1);
    chk("R4 B converted to one ownership read", ntx_b, 1);
    chk("R7 A writes back on ownership read", nwb, 1);
    single_writer(8'h15);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      chk("R9 watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule